// File: doc/BRIEF.md
# Five-Phase Stimulus Pattern Sequencer

This block drives the stimulus side of a comparison tester. A device under test and a known-good reference receive the same input patterns, and their outputs are compared. A free-running five-position ring produces three pulses, each one tick apart: a pattern advance, a device clock and a compare strobe. The advance pulse steps a binary pattern counter, so over time every input combination is applied. Each new pattern is followed by a clock for clocked parts and then by a strobe. The strobe marks the window in which the two devices' outputs may be compared safely.

The pattern counter is wider than the pattern bus, and only its lower bits leave the block. A test uses whatever slice of the bus it needs. Some storage elements have an undefined response when all four of their low inputs are high. For these, a remap can be switched on. While it is on, the all-ones code of the low four bits is presented as 1110, so 1110 appears on two consecutive steps.

Top module: `stim_pattern_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the ring is set to position 0 and the counter to zero. The outputs are then `pattern` = 0, `dev_clk` = 0 and `strobe` = 0.
- R2: Exactly one ring position is active at all times after reset. `dev_clk` and `strobe` are never high together, and neither stays high for two consecutive ticks.
- R3: Let n be the number of rising edges since reset was released. `dev_clk` is high exactly when n mod 5 = 2, and `strobe` is high exactly when n mod 5 = 3, which is one tick after the device clock.
- R4: The pattern counter steps by one once per five ticks. After n edges it holds floor((n+4)/5) modulo 2^CNT_W. A new pattern therefore appears one tick before `dev_clk` and stays for two ticks after `strobe`.
- R5: `pattern` carries bits OUT_W-1..0 of the counter, and the counter wraps to zero after 2^CNT_W steps. Counter bit k toggles every 5*2^k ticks, so the top bit of the default 12-bit counter has a period of 20480 ticks.
- R6: With `skip_en` = 1, bits 3..0 of `pattern` never read 1111. The count whose low four bits are 1111 is shown with bit 0 cleared (1110), and all other counts pass unchanged.
- R7: With `skip_en` = 0, `pattern` equals the counter's low bits with no change, including bit 0.
- R8: `skip_en` acts on `pattern` in the same cycle. It does not disturb the ring or the counter, so toggling it mid-run leaves the later sequence as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one ring tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| skip_en | input | 1 | High enables the 1111-to-1110 remap of the low four pattern bits |
| pattern | output | OUT_W | Stimulus pattern bus, low counter bits after the remap |
| dev_clk | output | 1 | One-tick device clock pulse, second phase after the pattern change |
| strobe | output | 1 | One-tick compare strobe pulse, one tick after `dev_clk` |

## Verification
The bench builds two copies side by side. The first keeps the default 12-bit counter and 10-bit bus. It is run far enough to reach count 1023 and the rollover of the visible bus at count 1024, and to see the remap at 0x3FF. The second uses a 5-bit counter with all five bits brought out. This puts the true top counter bit and the full counter wrap on the ports within a few hundred ticks. Both copies receive the same reset and remap control, so the remap and the phase spacing are checked at both widths.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

    // Ring position that steps the pattern counter
    localparam int ADV_POS  = 0;
    // Ring position presented as the device clock
    localparam int DCLK_POS = 2;
    // Ring position presented as the compare strobe
    localparam int STRB_POS = 3;

    typedef struct packed {
        logic adv;
        logic dclk;
        logic strb;
    } phase_taps_t;

    // Bit 0 of a remapped code: cleared when the remap is on and the
    // upper bits of the remap field are all ones
    function automatic logic remap_bit0(input logic b0,
                                        input logic upper_ones,
                                        input logic en);
        return b0 & ~(en & upper_ones);
    endfunction

endpackage

// File: rtl/phase_ring.sv
module phase_ring
    import stim_seq_pkg::*;
#(
    parameter int RING_LEN = 5
) (
    input  logic        clk,
    input  logic        rst,
    output phase_taps_t taps
);

    localparam int LAST = RING_LEN - 1;

    logic [RING_LEN-1:0] ring_q;
    logic [RING_LEN-1:0] ring_d;

    // Position 0 is refilled only when every other position but the
    // last is empty, so extra tokens shift out and an empty ring refills.
    assign ring_d[0] = ~|ring_q[LAST-1:0];

    generate
        for (genvar i = 1; i < RING_LEN; i++) begin : g_shift
            assign ring_d[i] = ring_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= RING_LEN'(1);
        end else begin
            ring_q <= ring_d;
        end
    end

    always_comb begin
        taps.adv  = ring_q[ADV_POS];
        taps.dclk = ring_q[DCLK_POS];
        taps.strb = ring_q[STRB_POS];
    end

    assert_single_token_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(ring_q) == 1);

    assert_ring_wraps_R3: assert property (@(posedge clk) disable iff (rst)
        ring_q[LAST] |=> ring_q[0]);

endmodule

// File: rtl/pattern_counter.sv
module pattern_counter #(
    parameter int CNT_W = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [OUT_W-1:0] cnt_lo
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_lo = cnt_q[OUT_W-1:0];

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
        adv |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    assert_hold_between_steps_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/skip_remap.sv
module skip_remap
    import stim_seq_pkg::*;
#(
    parameter int OUT_W  = 10,
    parameter int SKIP_W = 4
) (
    input  logic             skip_en,
    input  logic [OUT_W-1:0] cnt_lo,
    output logic [OUT_W-1:0] pat
);

    generate
        if (SKIP_W >= 2 && OUT_W >= SKIP_W) begin : g_remap
            logic upper_ones;
            assign upper_ones = &cnt_lo[SKIP_W-1:1];
            assign pat = {cnt_lo[OUT_W-1:1],
                          remap_bit0(cnt_lo[0], upper_ones, skip_en)};
        end else begin : g_pass
            logic unused_en;
            assign unused_en = skip_en;
            assign pat = cnt_lo;
        end
    endgenerate

endmodule

// File: rtl/stim_pattern_seq.sv
module stim_pattern_seq
    import stim_seq_pkg::*;
#(
    parameter int RING_LEN = 5,
    parameter int CNT_W    = 12,
    parameter int OUT_W    = 10,
    parameter int SKIP_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             skip_en,
    output logic [OUT_W-1:0] pattern,
    output logic             dev_clk,
    output logic             strobe
);

    phase_taps_t      taps;
    logic [OUT_W-1:0] cnt_lo;

    phase_ring #(.RING_LEN(RING_LEN)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .taps (taps)
    );

    pattern_counter #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (taps.adv),
        .cnt_lo (cnt_lo)
    );

    skip_remap #(.OUT_W(OUT_W), .SKIP_W(SKIP_W)) u_remap (
        .skip_en (skip_en),
        .cnt_lo  (cnt_lo),
        .pat     (pattern)
    );

    assign dev_clk = taps.dclk;
    assign strobe  = taps.strb;

    assert_strobe_follows_clock_R3: assert property (@(posedge clk) disable iff (rst)
        dev_clk |=> strobe);

    assert_pulses_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(dev_clk && strobe));

    assert_strobe_single_tick_R2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    assert_pattern_still_at_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        dev_clk && $stable(skip_en) |=> $stable(pattern));

    assert_no_all_ones_R6: assert property (@(posedge clk) disable iff (rst)
        skip_en |-> pattern[SKIP_W-1:0] != {SKIP_W{1'b1}});

    assert_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
        !skip_en |-> pattern == cnt_lo);

endmodule

// File: tb/test_stim_pattern_seq.sv
module test_stim_pattern_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       skip_en = 1'b0;
    logic [9:0] pattern;
    logic       dev_clk;
    logic       strobe;
    logic [4:0] s_pattern;
    logic       s_dev_clk;
    logic       s_strobe;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stim_pattern_seq i_stim_pattern_seq (
        .clk     (clk),
        .rst     (rst),
        .skip_en (skip_en),
        .pattern (pattern),
        .dev_clk (dev_clk),
        .strobe  (strobe)
    );

    stim_pattern_seq #(.CNT_W(5), .OUT_W(5)) i_small (
        .clk     (clk),
        .rst     (rst),
        .skip_en (skip_en),
        .pattern (s_pattern),
        .dev_clk (s_dev_clk),
        .strobe  (s_strobe)
    );

    typedef struct packed {
        logic [15:0] ticks;
        logic        skip;
        logic [9:0]  exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{16'd0,    1'b1, 10'h000},
        '{16'd5,    1'b1, 10'h001},
        '{16'd6,    1'b1, 10'h002},
        '{16'd70,   1'b1, 10'h00E},
        '{16'd71,   1'b1, 10'h00E},
        '{16'd71,   1'b0, 10'h00F},
        '{16'd76,   1'b1, 10'h010},
        '{16'd151,  1'b1, 10'h01E},
        '{16'd151,  1'b0, 10'h01F},
        '{16'd5111, 1'b1, 10'h3FE},
        '{16'd5111, 1'b0, 10'h3FF},
        '{16'd5116, 1'b0, 10'h000}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: outputs while reset is held
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pattern", 32'(pattern), 32'h0);
        check("R1 dev_clk", 32'(dev_clk), 32'h0);
        check("R1 strobe", 32'(strobe), 32'h0);
        check("R1 small pattern", 32'(s_pattern), 32'h0);

        // Vector table: R4 counting, R6 remap, R7 pass-through, R5 bus rollover
        for (int v = 0; v < NVEC; v++) begin
            skip_en = VECS[v].skip;
            do_reset();
            step(int'(VECS[v].ticks));
            check(VECS[v].skip ? "R4/R6 table" : "R4/R7 table",
                  32'(pattern), 32'(VECS[v].exp));
        end

        // R3 and R2: phase placement over several ring cycles
        skip_en = 1'b0;
        do_reset();
        for (int n = 0; n < 25; n++) begin
            check("R3 dev_clk phase", 32'(dev_clk), 32'((n % 5) == 2));
            check("R3 strobe phase", 32'(strobe), 32'((n % 5) == 3));
            check("R2 exclusive", 32'(dev_clk & strobe), 32'h0);
            check("R4 running count", 32'(pattern), 32'((n + 4) / 5));
            step(1);
        end

        // R8: remap toggled mid-run acts at once and leaves the count alone
        skip_en = 1'b1;
        do_reset();
        step(71);
        check("R8 remap on", 32'(pattern), 32'h00E);
        skip_en = 1'b0;
        #1;
        check("R8 remap off same cycle", 32'(pattern), 32'h00F);
        skip_en = 1'b1;
        #1;
        check("R8 remap back on", 32'(pattern), 32'h00E);
        step(5);
        check("R8 count undisturbed", 32'(pattern), 32'h010);

        // R5: small copy exposes the full counter and its wrap
        skip_en = 1'b0;
        do_reset();
        step(36);
        check("R5 top bit low at count 8", 32'(s_pattern[4]), 32'h0);
        step(40);
        check("R5 top bit high at count 16", 32'(s_pattern), 32'h10);
        step(79);
        check("R5 full count 31", 32'(s_pattern), 32'h1F);
        step(1);
        check("R5 counter wraps", 32'(s_pattern), 32'h00);
        check("R3 small strobe after wrap", 32'(s_strobe), 32'h0);
        skip_en = 1'b1;
        step(75);
        check("R6 small remap at count 15", 32'(s_pattern), 32'h0E);
        check("R3 small dev_clk phase", 32'(s_dev_clk), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule